// File: doc/BRIEF.md
# Double-Buffered Universe Channel Store

This block keeps the channel levels for one lighting universe in two banks of 512 eight-bit entries. At any moment one bank is the control bank, which the producer side reads and writes. The other bank is the display bank, which the consumer side reads. Both sides work in the same clock cycle without waiting for each other.

A single-cycle swap request exchanges the two roles at the next clock edge. A producer therefore fills the control bank over a whole frame, then issues a swap so the consumer sees a complete new frame at once. A status output reports which bank is currently under control.

A swap copies nothing. The bank that becomes the control bank still holds the frame that was last shown from it. Memory is not cleared by reset. Read data on both sides is registered, and it holds its value until the next read on that side.

Top module: `univ_dbuf_store`

## Requirements
- R1: After reset `ctrl_bank` is 0 (bank 0 is the control bank, bank 1 the display bank), and `in_rdata` and `out_rdata` are 0.
- R2: A producer read (`in_en`=1, `in_we`=0) of an address returns the value last written there by the producer while the same bank was the control bank. The value appears on `in_rdata` just after the clock edge that samples the read.
- R3: A producer write (`in_en`=1, `in_we`=1) changes only the control bank. Consumer reads of the same address return the old display-bank value until a swap occurs.
- R4: A consumer read (`out_en`=1) returns data from the bank that is not the control bank, one cycle after the read is sampled.
- R5: When `swap_req` is 1 at a clock edge, `ctrl_bank` inverts at that edge. When `swap_req` is 0, `ctrl_bank` keeps its value.
- R6: Any producer or consumer access sampled at the same edge as a swap uses the bank roles from before the swap, so it is neither lost nor split across banks.
- R7: A producer access and a consumer access in the same cycle both complete, including when they use the same address.
- R8: `in_rdata` changes only after a producer read, and `out_rdata` changes only after a consumer read. Producer writes, idle cycles and swaps leave both values unchanged.
- R9: A swap copies no data. The new control bank holds exactly what it held while it was the display bank.
- R10: All 512 addresses, from 0 to 511, are stored independently within each bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_en | input | 1 | Producer access enable |
| in_we | input | 1 | Producer write (1) or read (0) when enabled |
| in_addr | input | 9 | Producer channel address |
| in_wdata | input | 8 | Producer write value |
| in_rdata | output | 8 | Producer read value, registered |
| out_en | input | 1 | Consumer read enable |
| out_addr | input | 9 | Consumer channel address |
| out_rdata | output | 8 | Consumer read value, registered |
| swap_req | input | 1 | Single-cycle request to exchange bank roles |
| ctrl_bank | output | 1 | Index of the current control bank |

## Verification
The store is filled with an address-derived pattern over the full address range, and every entry is read back. This exposes any aliasing between addresses and any fault at address 0 or 511. A second, different pattern is then loaded into the other bank while the consumer keeps reading the first. This separates correct bank routing from writes that leak into the display bank, and it shows whether a swap copies data. The bench also puts a swap, a producer write and a consumer read at the same address in one cycle, which reveals whether the edge that swaps also applies the new roles to that cycle's accesses. Finally, it runs idle, write-only and swap-only cycles after known reads to confirm that the read registers hold their values.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

  // Role identity of a storage bank
  typedef enum logic {
    BANK_ZERO = 1'b0,
    BANK_ONE  = 1'b1
  } bank_id_t;

  localparam int unsigned FB_NUM_BANKS = 2;

  // The bank that is presented to the consumer side
  function automatic bank_id_t fb_display_of(input bank_id_t ctrl);
    return (ctrl == BANK_ZERO) ? BANK_ONE : BANK_ZERO;
  endfunction

endpackage

// File: rtl/fbuf_swap_ctrl.sv
module fbuf_swap_ctrl
  import fbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     swap_req,
  output bank_id_t ctrl_bank
);

  bank_id_t ctrl_q;
  bank_id_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (swap_req) begin
      ctrl_d = fb_display_of(ctrl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= BANK_ZERO;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_bank = ctrl_q;

  // R5
  swap_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |=> (ctrl_q != $past(ctrl_q)));

  // R5
  no_swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_req |=> $stable(ctrl_q));

endmodule

// File: rtl/fbuf_route.sv
module fbuf_route
  import fbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  bank_id_t                            ctrl_bank,
  input  logic                                in_en,
  input  logic                                in_we,
  input  logic [ADDR_W-1:0]                   in_addr,
  input  logic [ADDR_W-1:0]                   out_addr,
  output logic [FB_NUM_BANKS-1:0]             bank_we,
  output logic [FB_NUM_BANKS-1:0][ADDR_W-1:0] bank_addr
);

  // Each bank serves exactly one side at a time, so a single address
  // per bank is enough; the role decides which side drives it.
  for (genvar b = 0; b < FB_NUM_BANKS; b++) begin : g_bank_req
    logic owned_by_ctrl;

    always_comb begin
      owned_by_ctrl = (ctrl_bank == bank_id_t'(b));
      bank_we[b]    = owned_by_ctrl && in_en && in_we;
      bank_addr[b]  = owned_by_ctrl ? in_addr : out_addr;
    end
  end

  // R3
  single_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R3
  display_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we[fb_display_of(ctrl_bank)]);

endmodule

// File: rtl/fbuf_bank.sv
module fbuf_bank #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  // Contents are deliberately left uninitialised by reset.
  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[addr] <= wdata;
    end
  end

  assign rdata = store_q[addr];

endmodule

// File: rtl/fbuf_rd_port.sv
module fbuf_rd_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (rd_en) begin
      data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign dout = data_q;

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(data_q));

endmodule

// File: rtl/univ_dbuf_store.sv
module univ_dbuf_store
  import fbuf_pkg::*;
#(
  parameter int unsigned CHANNELS = 512,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned ADDR_W  = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic              in_we,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [DATA_W-1:0] in_rdata,
  input  logic              out_en,
  input  logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_rdata,
  input  logic              swap_req,
  output logic              ctrl_bank
);

  bank_id_t                            role_ctrl;
  bank_id_t                            role_disp;
  logic [FB_NUM_BANKS-1:0]             bank_we;
  logic [FB_NUM_BANKS-1:0][ADDR_W-1:0] bank_addr;
  logic [FB_NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic                                in_rd_en;
  logic [DATA_W-1:0]                   in_sel_data;
  logic [DATA_W-1:0]                   out_sel_data;

  fbuf_swap_ctrl u_swap (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .ctrl_bank (role_ctrl)
  );

  assign role_disp = fb_display_of(role_ctrl);

  fbuf_route #(
    .ADDR_W (ADDR_W)
  ) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_bank (role_ctrl),
    .in_en     (in_en),
    .in_we     (in_we),
    .in_addr   (in_addr),
    .out_addr  (out_addr),
    .bank_we   (bank_we),
    .bank_addr (bank_addr)
  );

  for (genvar b = 0; b < FB_NUM_BANKS; b++) begin : g_bank
    fbuf_bank #(
      .DEPTH  (CHANNELS),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .addr  (bank_addr[b]),
      .wdata (in_wdata),
      .rdata (bank_rdata[b])
    );
  end

  // Data is selected with the roles of the sampling cycle, so a read that
  // coincides with a swap still returns the pre-swap bank.
  always_comb begin
    in_rd_en     = in_en && !in_we;
    in_sel_data  = bank_rdata[role_ctrl];
    out_sel_data = bank_rdata[role_disp];
  end

  fbuf_rd_port #(
    .DATA_W (DATA_W)
  ) u_in_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (in_rd_en),
    .din   (in_sel_data),
    .dout  (in_rdata)
  );

  fbuf_rd_port #(
    .DATA_W (DATA_W)
  ) u_out_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (out_en),
    .din   (out_sel_data),
    .dout  (out_rdata)
  );

  assign ctrl_bank = (role_ctrl == BANK_ONE);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable(out_rdata));

  // R8
  write_no_rd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && in_we) |=> $stable(in_rdata));

endmodule

// File: tb/test_univ_dbuf_store.sv
module test_univ_dbuf_store;

  localparam int CH = 512;

  logic       clk;
  logic       rst_n;
  logic       in_en, in_we;
  logic [8:0] in_addr;
  logic [7:0] in_wdata;
  logic [7:0] in_rdata;
  logic       out_en;
  logic [8:0] out_addr;
  logic [7:0] out_rdata;
  logic       swap_req;
  logic       ctrl_bank;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] ref_mem [2][CH];
  bit         exp_ctrl;

  univ_dbuf_store i_univ_dbuf_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_en     (in_en),
    .in_we     (in_we),
    .in_addr   (in_addr),
    .in_wdata  (in_wdata),
    .in_rdata  (in_rdata),
    .out_en    (out_en),
    .out_addr  (out_addr),
    .out_rdata (out_rdata),
    .swap_req  (swap_req),
    .ctrl_bank (ctrl_bank)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    in_en = 0; in_we = 0; out_en = 0; swap_req = 0;
  endtask

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 37 + 5) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] pat_b(input int a);
    return 8'((a * 91 + 200) ^ 8'hA5);
  endfunction

  task automatic in_write(input int a, input logic [7:0] d);
    in_en = 1; in_we = 1; in_addr = 9'(a); in_wdata = d;
    step();
    in_en = 0; in_we = 0;
    ref_mem[exp_ctrl][a] = d;
  endtask

  task automatic in_read(input int a, output logic [7:0] d);
    in_en = 1; in_we = 0; in_addr = 9'(a);
    step();
    in_en = 0;
    d = in_rdata;
  endtask

  task automatic out_read(input int a, output logic [7:0] d);
    out_en = 1; out_addr = 9'(a);
    step();
    out_en = 0;
    d = out_rdata;
  endtask

  task automatic do_swap();
    swap_req = 1;
    step();
    swap_req = 0;
    exp_ctrl = ~exp_ctrl;
  endtask

  // R1
  task automatic t_reset();
    chk(ctrl_bank == 1'b0, "R1 ctrl_bank", int'(ctrl_bank), 0);
    chk(in_rdata == 8'h00, "R1 in_rdata", int'(in_rdata), 0);
    chk(out_rdata == 8'h00, "R1 out_rdata", int'(out_rdata), 0);
  endtask

  // R2 R10: full range in control bank 0
  task automatic t_fill_and_read();
    logic [7:0] d;
    for (int a = 0; a < CH; a++) in_write(a, pat_a(a));
    for (int a = 0; a < CH; a++) begin
      in_read(a, d);
      chk(d == pat_a(a), (a == 0 || a == CH - 1) ? "R10 edge address" : "R2 readback",
          int'(d), int'(pat_a(a)));
    end
  endtask

  // R5 R4 R3 R9
  task automatic t_swap_roles();
    logic [7:0] d;
    chk(ctrl_bank == 1'b0, "R5 ctrl before swap", int'(ctrl_bank), 0);
    do_swap();
    chk(ctrl_bank == 1'b1, "R5 ctrl after swap", int'(ctrl_bank), 1);
    for (int a = 0; a < CH; a += 17) begin
      out_read(a, d);
      chk(d == pat_a(a), "R4 display shows old control", int'(d), int'(pat_a(a)));
    end
    for (int a = 0; a < CH; a++) in_write(a, pat_b(a));
    for (int a = 0; a < CH; a += 13) begin
      out_read(a, d);
      chk(d == pat_a(a), "R3 write isolated from display", int'(d), int'(pat_a(a)));
      in_read(a, d);
      chk(d == pat_b(a), "R10 bank one readback", int'(d), int'(pat_b(a)));
    end
    repeat (3) step();
    chk(ctrl_bank == 1'b1, "R5 hold without swap", int'(ctrl_bank), 1);
    do_swap();
    chk(ctrl_bank == 1'b0, "R5 second swap", int'(ctrl_bank), 0);
    for (int a = 0; a < CH; a += 11) begin
      in_read(a, d);
      chk(d == pat_a(a), "R9 no copy on swap", int'(d), int'(pat_a(a)));
      out_read(a, d);
      chk(d == pat_b(a), "R4 new display", int'(d), int'(pat_b(a)));
    end
  endtask

  // R6: ctrl=0 here; bank0 holds pat_a, bank1 holds pat_b
  task automatic t_swap_cycle_access();
    logic [7:0] d;
    swap_req = 1;
    in_en = 1; in_we = 1; in_addr = 9'd7; in_wdata = 8'h5A;
    out_en = 1; out_addr = 9'd7;
    step();
    idle_inputs();
    ref_mem[exp_ctrl][7] = 8'h5A;
    chk(out_rdata == pat_b(7), "R6 swap-cycle read uses old display",
        int'(out_rdata), int'(pat_b(7)));
    exp_ctrl = ~exp_ctrl;
    chk(ctrl_bank == exp_ctrl, "R6 ctrl toggled", int'(ctrl_bank), int'(exp_ctrl));
    out_read(7, d);
    chk(d == 8'h5A, "R6 swap-cycle write landed in old control", int'(d), 8'h5A);
    in_read(7, d);
    chk(d == pat_b(7), "R6 new control untouched", int'(d), int'(pat_b(7)));
    // same-cycle producer read during swap returns pre-swap control bank
    swap_req = 1;
    in_en = 1; in_we = 0; in_addr = 9'd7;
    step();
    idle_inputs();
    chk(in_rdata == pat_b(7), "R6 swap-cycle producer read", int'(in_rdata), int'(pat_b(7)));
    exp_ctrl = ~exp_ctrl;
    chk(ctrl_bank == exp_ctrl, "R5 ctrl after swap read", int'(ctrl_bank), int'(exp_ctrl));
  endtask

  // R7: ctrl=0 here, bank0 addr7=0x5A, bank1 = pat_b
  task automatic t_simultaneous();
    logic [7:0] d;
    in_en = 1; in_we = 1; in_addr = 9'd100; in_wdata = 8'hC3;
    out_en = 1; out_addr = 9'd100;
    step();
    idle_inputs();
    ref_mem[exp_ctrl][100] = 8'hC3;
    chk(out_rdata == pat_b(100), "R7 parallel read during write",
        int'(out_rdata), int'(pat_b(100)));
    in_en = 1; in_we = 0; in_addr = 9'd100;
    out_en = 1; out_addr = 9'd200;
    step();
    idle_inputs();
    chk(in_rdata == 8'hC3, "R7 parallel producer read", int'(in_rdata), 8'hC3);
    chk(out_rdata == pat_b(200), "R7 parallel consumer read",
        int'(out_rdata), int'(pat_b(200)));
    in_read(7, d);
    chk(d == 8'h5A, "R7 earlier write kept", int'(d), 8'h5A);
  endtask

  // R8
  task automatic t_hold();
    logic [7:0] vi, vo;
    in_read(100, vi);
    out_read(300, vo);
    in_write(5, 8'h11);
    chk(in_rdata == vi, "R8 in_rdata after write", int'(in_rdata), int'(vi));
    chk(out_rdata == vo, "R8 out_rdata after producer write", int'(out_rdata), int'(vo));
    repeat (4) step();
    chk(in_rdata == vi, "R8 in_rdata idle", int'(in_rdata), int'(vi));
    do_swap();
    chk(in_rdata == vi, "R8 in_rdata across swap", int'(in_rdata), int'(vi));
    chk(out_rdata == vo, "R8 out_rdata across swap", int'(out_rdata), int'(vo));
    out_read(5, vo);
    chk(vo == 8'h11, "R4 display after swap", int'(vo), 8'h11);
  endtask

  initial begin
    rst_n = 0;
    in_addr = '0; in_wdata = '0; out_addr = '0;
    idle_inputs();
    exp_ctrl = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_fill_and_read();
    t_swap_roles();
    t_swap_cycle_access();
    t_simultaneous();
    t_hold();
    summary();
    $finish;
  end

endmodule